// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

The block is a watchdog built around a down-counter. The counter steps once per tick of a power-of-two prescaler. Software talks to the block only through a simple write bus, and it starts and services the watchdog by writing exact 16-bit key values to a key register. The prescaler and reload registers are write-protected. They accept data only after the unlock key has been written. Each accepted value passes through a short synchronisation delay before it becomes active, and a busy flag stays high while that delay runs.

Once started, the watchdog cannot be stopped except by a system reset. If software does not refresh it in time, the counter runs down to zero. The block then raises a one-cycle reset request and reloads itself.

A four-state controller tracks two things at once: whether the counter is running, and whether configuration access is open. Its states are `WD_IDLE_LOCKED`, `WD_IDLE_OPEN`, `WD_RUN_LOCKED` and `WD_RUN_OPEN`. The transitions are:
- **start** (key 0xCCCC): IDLE_x to RUN_x, with access left as it was.
- **open** (key 0x5555): x_LOCKED to x_OPEN.
- **close** (key 0x0000): x_OPEN to x_LOCKED.
- **refresh** (key 0xAAAA): x_OPEN to x_LOCKED, and while running it also reloads the counter.

No transition leaves a RUN state for an IDLE state.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `running` and `reset_req` are 0, `count_value` is 0xFFF, both busy flags are 0, the prescaler code is 0 (divide by 4) and access is locked.
- R2: Writing 0xCCCC to the key address (0) loads the counter from the active reload value and starts it. With reload R and divide D, the first `reset_req` comes (R+1)*D cycles after the write edge, and `count_value` drops by one every D cycles.
- R3: `reset_req` is high for exactly one cycle. In that cycle `count_value` already holds the reload value, and the next request follows (R+1)*D cycles later.
- R4: The key 0xAAAA reloads the running counter from the active reload value and locks configuration access again.
- R5: The key 0x5555 opens write access to the prescaler (address 1, data bits [2:0]) and reload (address 2, data bits [11:0]) registers, and the key 0x0000 closes it.
- R6: A write to the prescaler or reload register while access is locked is ignored: no busy flag is raised and the active value does not change.
- R7: Any key value other than the four listed is ignored and changes neither the run state nor the access state.
- R8: The key 0xCCCC while running does not reload the counter, and no key stops a running watchdog.
- R9: Prescaler code c divides by 4<<c for c from 0 to 6, and code 7 divides by 256.
- R10: An accepted prescaler or reload write sets that register's busy flag (`pre_busy` or `rld_busy`) at once. The flag clears exactly SYNC_CYCLES (3) clock cycles later, and the new value becomes active at that moment.
- R11: A reload value of 0 gives a reset request on every prescaler period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 2 | Register address: 0 key, 1 prescaler, 2 reload, 3 read-only |
| wr_data | input | 16 | Write data |
| running | output | 1 | Watchdog counter is enabled |
| reset_req | output | 1 | One-cycle reset request on counter expiry |
| count_value | output | 12 | Current down-counter value |
| pre_busy | output | 1 | Prescaler update is being synchronised |
| rld_busy | output | 1 | Reload update is being synchronised |

## Verification
The bench measures the exact cycle of the first and the following reset requests, for several combinations of prescaler code and reload value, including code 7 and reload 0. This catches an off-by-one count (a request one prescaler period early or late), a ratio table that wraps code 7 to a small divisor, and a request that lasts longer than one cycle.

Writes to protected registers are tried in four conditions: while locked, after open followed by close, after a refresh, and with near-miss keys. A design that decoded keys loosely, or forgot to relock on refresh, would show a busy flag or run with the wrong reload.

The bench also writes the start key a second time while running. A design that treated that key as a reload would show a fresh `count_value`.

// File: rtl/wd_pkg.sv
`timescale 1ns/1ps
package wd_pkg;
    localparam int KEY_W = 16;

    localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;
    localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_OPEN    = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_CLOSE   = 16'h0000;

    localparam logic [1:0] ADDR_KEY = 2'd0;
    localparam logic [1:0] ADDR_PRE = 2'd1;
    localparam logic [1:0] ADDR_RLD = 2'd2;

    typedef enum logic [1:0] {
        WD_IDLE_LOCKED = 2'b00,
        WD_IDLE_OPEN   = 2'b01,
        WD_RUN_LOCKED  = 2'b10,
        WD_RUN_OPEN    = 2'b11
    } wd_state_e;
endpackage

// File: rtl/wd_key_fsm.sv
`timescale 1ns/1ps
module wd_key_fsm
    import wd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    output logic             running,
    output logic             cfg_open,
    output logic             start_pulse,
    output logic             refresh_pulse
);
    wd_state_e state, state_nxt;

    logic is_start, is_refresh, is_open, is_close;
    assign is_start   = key_wr && (key_val == KEY_START);
    assign is_refresh = key_wr && (key_val == KEY_REFRESH);
    assign is_open    = key_wr && (key_val == KEY_OPEN);
    assign is_close   = key_wr && (key_val == KEY_CLOSE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WD_IDLE_LOCKED;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            WD_IDLE_LOCKED: begin
                if (is_start)     state_nxt = WD_RUN_LOCKED;
                else if (is_open) state_nxt = WD_IDLE_OPEN;
            end
            WD_IDLE_OPEN: begin
                if (is_start)                    state_nxt = WD_RUN_OPEN;
                else if (is_refresh || is_close) state_nxt = WD_IDLE_LOCKED;
            end
            WD_RUN_LOCKED: begin
                if (is_open) state_nxt = WD_RUN_OPEN;
            end
            WD_RUN_OPEN: begin
                if (is_refresh || is_close) state_nxt = WD_RUN_LOCKED;
            end
        endcase
    end

    always_comb begin
        running       = (state == WD_RUN_LOCKED) || (state == WD_RUN_OPEN);
        cfg_open      = (state == WD_IDLE_OPEN)  || (state == WD_RUN_OPEN);
        start_pulse   = is_start && !running;
        refresh_pulse = is_refresh && running;
    end
endmodule

// File: rtl/wd_shadow_reg.sv
`timescale 1ns/1ps
module wd_shadow_reg #(
    parameter int               W           = 12,
    parameter logic [W-1:0]     RST_VAL     = '0,
    parameter int               SYNC_CYCLES = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] active,
    output logic         busy
);
    localparam int SC_W = $clog2(SYNC_CYCLES + 1);
    localparam logic [SC_W-1:0] SC_INIT = SC_W'(SYNC_CYCLES);

    logic [W-1:0]    staged;
    logic [SC_W-1:0] sc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            staged <= RST_VAL;
            active <= RST_VAL;
            busy   <= 1'b0;
            sc     <= '0;
        end else if (load) begin
            staged <= din;
            busy   <= 1'b1;
            sc     <= SC_INIT;
        end else if (busy) begin
            sc <= sc - 1'b1;
            if (sc == SC_W'(1)) begin
                busy   <= 1'b0;
                active <= staged;
            end
        end
    end
endmodule

// File: rtl/wd_prescaler.sv
`timescale 1ns/1ps
module wd_prescaler #(
    parameter int CODE_W   = 3,
    parameter int BASE_LOG = 2,
    parameter int MAX_LOG  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int CNT_W = MAX_LOG;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    always_comb begin
        int unsigned sel;
        sel = BASE_LOG + 32'(code);
        if (sel > MAX_LOG) sel = MAX_LOG;
        limit = CNT_W'((33'd1 << sel) - 33'd1);
        tick  = run && (cnt >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (!run) cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/keyed_watchdog.sv
`timescale 1ns/1ps
module keyed_watchdog
    import wd_pkg::*;
#(
    parameter int RLD_W       = 12,
    parameter int PRE_W       = 3,
    parameter int SYNC_CYCLES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [15:0]      wr_data,
    output logic             running,
    output logic             reset_req,
    output logic [RLD_W-1:0] count_value,
    output logic             pre_busy,
    output logic             rld_busy
);
    logic             cfg_open, start_pulse, refresh_pulse, tick;
    logic [RLD_W-1:0] rld_active;
    logic [PRE_W-1:0] pre_active;
    logic             key_wr, pre_load, rld_load;

    assign key_wr   = wr_en && (wr_addr == ADDR_KEY);
    assign pre_load = wr_en && (wr_addr == ADDR_PRE) && cfg_open;
    assign rld_load = wr_en && (wr_addr == ADDR_RLD) && cfg_open;

    wd_key_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_val(wr_data[KEY_W-1:0]),
        .running(running), .cfg_open(cfg_open),
        .start_pulse(start_pulse), .refresh_pulse(refresh_pulse)
    );

    wd_shadow_reg #(.W(PRE_W), .RST_VAL('0), .SYNC_CYCLES(SYNC_CYCLES)) u_pre (
        .clk(clk), .rst_n(rst_n), .load(pre_load), .din(wr_data[PRE_W-1:0]),
        .active(pre_active), .busy(pre_busy)
    );

    wd_shadow_reg #(.W(RLD_W), .RST_VAL('1), .SYNC_CYCLES(SYNC_CYCLES)) u_rld (
        .clk(clk), .rst_n(rst_n), .load(rld_load), .din(wr_data[RLD_W-1:0]),
        .active(rld_active), .busy(rld_busy)
    );

    wd_prescaler #(.CODE_W(PRE_W), .BASE_LOG(2), .MAX_LOG(8)) u_div (
        .clk(clk), .rst_n(rst_n), .run(running), .code(pre_active), .tick(tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_value <= '1;
            reset_req   <= 1'b0;
        end else begin
            reset_req <= 1'b0;
            if (start_pulse || refresh_pulse) begin
                count_value <= rld_active;
            end else if (tick) begin
                if (count_value == '0) begin
                    count_value <= rld_active;
                    reset_req   <= 1'b1;
                end else begin
                    count_value <= count_value - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wd_checker.sv
`timescale 1ns/1ps
module wd_checker #(
    parameter int RLD_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic             running,
    input logic             reset_req,
    input logic [RLD_W-1:0] count_value,
    input logic             pre_busy,
    input logic             rld_busy,
    input logic             cfg_open,
    input logic [RLD_W-1:0] rld_active
);
    p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    p_req_reloaded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (count_value == $past(rld_active)));

    p_no_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !reset_req);

    p_pre_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pre_busy) |-> $past(wr_en && wr_addr == 2'd1 && cfg_open));

    p_rld_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rld_busy) |-> $past(wr_en && wr_addr == 2'd2 && cfg_open));
endmodule

bind keyed_watchdog wd_checker #(.RLD_W(RLD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .running(running), .reset_req(reset_req), .count_value(count_value),
    .pre_busy(pre_busy), .rld_busy(rld_busy), .cfg_open(cfg_open),
    .rld_active(rld_active)
);

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        running, reset_req, pre_busy, rld_busy;
    logic [11:0] count_value;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    keyed_watchdog uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .running(running), .reset_req(reset_req), .count_value(count_value),
        .pre_busy(pre_busy), .rld_busy(rld_busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_req(input int limit, output int k);
        k = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (reset_req) begin k = i; return; end
        end
    endtask

    task automatic configure(input logic [2:0] code, input logic [11:0] rld);
        bus_write(2'd0, 16'h5555);
        bus_write(2'd1, {13'd0, code});
        bus_write(2'd2, {4'd0, rld});
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        check(running == 1'b0, "R1 running", running, 0);
        check(reset_req == 1'b0, "R1 reset_req", reset_req, 0);
        check(count_value == 12'hFFF, "R1 count", count_value, 12'hFFF);
        check(!pre_busy && !rld_busy, "R1 busy", {pre_busy, rld_busy}, 0);
    endtask

    task automatic t_locked_writes();
        do_reset();
        bus_write(2'd2, 16'd5);
        check(rld_busy == 1'b0, "R6 locked reload write", rld_busy, 0);
        bus_write(2'd1, 16'd3);
        check(pre_busy == 1'b0, "R6 locked prescaler write", pre_busy, 0);
        bus_write(2'd0, 16'h5555);
        bus_write(2'd0, 16'h0000);
        bus_write(2'd2, 16'd5);
        check(rld_busy == 1'b0, "R5 close key relocks", rld_busy, 0);
        bus_write(2'd0, 16'hCCCC);
        check(count_value == 12'hFFF, "R6 reload unchanged", count_value, 12'hFFF);
    endtask

    task automatic t_sync_and_expiry();
        int k;
        do_reset();
        bus_write(2'd0, 16'h5555);
        bus_write(2'd2, 16'd3);
        check(rld_busy == 1'b1, "R10 busy set", rld_busy, 1);
        repeat (2) @(negedge clk);
        check(rld_busy == 1'b1, "R10 busy held", rld_busy, 1);
        @(negedge clk);
        check(rld_busy == 1'b0, "R10 busy cleared", rld_busy, 0);
        bus_write(2'd0, 16'hCCCC);
        check(running == 1'b1, "R2 running", running, 1);
        check(count_value == 12'd3, "R2 loaded", count_value, 3);
        wait_req(100, k);
        check(k == 16, "R2 first request", k, 16);
        check(count_value == 12'd3, "R3 reload on expiry", count_value, 3);
        @(negedge clk);
        check(reset_req == 1'b0, "R3 one cycle", reset_req, 0);
        wait_req(100, k);
        check(k == 15, "R3 second request", k, 15);
    endtask

    task automatic t_bad_keys();
        do_reset();
        bus_write(2'd0, 16'hCCCD);
        bus_write(2'd0, 16'h5556);
        bus_write(2'd0, 16'hAAAB);
        bus_write(2'd3, 16'hCCCC);
        check(running == 1'b0, "R7 not started", running, 0);
        bus_write(2'd2, 16'd7);
        check(rld_busy == 1'b0, "R7 not unlocked", rld_busy, 0);
    endtask

    task automatic t_refresh();
        do_reset();
        configure(3'd0, 12'd3);
        bus_write(2'd0, 16'hCCCC);
        repeat (6) @(negedge clk);
        check(count_value < 12'd3, "R4 counted down", count_value, 2);
        bus_write(2'd0, 16'hAAAA);
        check(count_value == 12'd3, "R4 refresh reload", count_value, 3);
        bus_write(2'd2, 16'd9);
        check(rld_busy == 1'b0, "R4 refresh relocks", rld_busy, 0);
    endtask

    task automatic t_restart_ignored();
        do_reset();
        bus_write(2'd0, 16'hCCCC);
        repeat (20) @(negedge clk);
        check(count_value == 12'hFFA, "R2 decrement rate", count_value, 12'hFFA);
        bus_write(2'd0, 16'hCCCC);
        check(count_value == 12'hFFA, "R8 start ignored", count_value, 12'hFFA);
        bus_write(2'd0, 16'h0000);
        bus_write(2'd0, 16'h1234);
        check(running == 1'b1, "R8 still running", running, 1);
    endtask

    task automatic t_prescale(input logic [2:0] code, input logic [11:0] rld, input int exp);
        int k;
        do_reset();
        configure(code, rld);
        bus_write(2'd0, 16'hCCCC);
        wait_req(2000, k);
        check(k == exp, $sformatf("R9 code %0d reload %0d", code, rld), k, exp);
    endtask

    task automatic t_zero_reload();
        int k;
        do_reset();
        configure(3'd0, 12'd0);
        bus_write(2'd0, 16'hCCCC);
        wait_req(50, k);
        check(k == 4, "R11 first", k, 4);
        wait_req(50, k);
        check(k == 4, "R11 repeat", k, 4);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_locked_writes();
        t_sync_and_expiry();
        t_bad_keys();
        t_refresh();
        t_restart_ignored();
        t_prescale(3'd2, 12'd1, 32);
        t_prescale(3'd6, 12'd0, 256);
        t_prescale(3'd7, 12'd0, 256);
        t_zero_reload();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule